// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the clock line waveform for an I2C master. It works from a one-cycle base clock enable (`tick`). Two inputs choose the rate: a standard/fast select and a 5-bit divider code. The block drives the line open-drain style: `scl_drive_low` set means pull the line low, and clear means release it. It also watches the sensed line level. A slow target that holds the line low after a release therefore delays the start of the counted high phase. Stretching can only lower the rate, never raise it.

In standard mode each half period is 4 × code ticks. In fast mode each half period is 2 × code ticks. One fast-mode code gets special handling: code 5 gives a fixed 10-tick period split 6 low / 4 high. This keeps the low time at or above the bus minimum at the top fast rate. Some codes would exceed the mode's rate limit or cannot be used at all. For these codes the block raises `cfg_error` and never starts pulling the line low. Two one-cycle strobes mark where each counted high phase starts and where each low phase starts, for use by a data shifter.

The controller is a four-state machine:
- `ST_IDLE`: released, not generating.
- `ST_WAIT_LINE`: released, waiting for the sensed line to read high on a tick.
- `ST_HIGH_CNT`: released, counting high ticks.
- `ST_LOW_CNT`: driving low, counting low ticks.

Transitions:
- IDLE→WAIT_LINE when `enable` is set and the configuration is legal.
- WAIT_LINE→HIGH_CNT on a tick with the line high.
- HIGH_CNT→LOW_CNT on the last high tick.
- LOW_CNT→WAIT_LINE on the last low tick if the configuration is still legal.
- LOW_CNT→IDLE on the last low tick if the configuration has become illegal.
- Any state→IDLE when `enable` is low.

Top module: `scl_rate_gen`

## Requirements
- R1: Standard mode (`fast_mode`=0), codes 5..31: each low phase lasts 4×code ticks and each high phase 4×code ticks.
- R2: Fast mode (`fast_mode`=1), codes 3, 4 and 6..31: each low phase lasts 2×code ticks and each high phase 2×code ticks.
- R3: Fast mode with code 5: each low phase lasts 6 ticks and each high phase 4 ticks.
- R4: Error flag and illegal codes.
  - `cfg_error` is 1 for codes 0, 1 and 2 in either mode, and for codes 3 and 4 in standard mode. It is 0 for every other code.
  - With such a code applied, `scl_drive_low` never goes to 1 after `enable` is set.
- R5: Every low phase that ends with `enable` still set lasts at least 6 ticks.
- R6: After the line is released, high ticks are counted only once the sensed line reads high. While an external device holds the line low, `scl_drive_low` stays 0 and no `scl_rise` occurs.
- R7: Reset and enable.
  - After reset, and after `enable` is set, the line is released.
  - One clock after `enable` falls, `scl_drive_low` is 0.
- R8: Changes to mode or code take effect only at the end of a low phase. A change during a high phase leaves that phase and the following low phase unchanged. The high phase after that uses the new setting. If the new setting is illegal, generation stops released at that boundary.
- R9: Strobes.
  - `scl_fall` is high for exactly the first cycle of each low phase.
  - `scl_rise` is high for one cycle per high phase, in the cycle after the first counted high tick.
  - The two strobes are never high together.
- R10: Only cycles with `tick`=1 advance the phase counts. A low phase of N ticks, with one tick every K cycles, spans N×K clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base clock enable; one pulse per base period |
| enable | input | 1 | Run the generator; low forces released and idle |
| fast_mode | input | 1 | 0 selects standard mode, 1 selects fast mode |
| div_code | input | 5 | Divider code |
| scl_sense | input | 1 | Sensed level of the clock line |
| scl_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| scl_rise | output | 1 | One-cycle strobe at start of the counted high phase |
| scl_fall | output | 1 | One-cycle strobe on the first cycle of a low phase |
| cfg_error | output | 1 | Mode/code combination is not allowed |

## Verification
The hardest situation to reach from the ports is the line held low by a target just after the block releases it. That case has to be timed against the block's own release. The bench models the open-drain line as the release ANDed with a stretch control. It raises the stretch during a low phase, so the hold begins exactly at release, and it drops the stretch 30 cycles later. It then counts only the ticks seen with the line high. A second hard case is a divider change that lands inside a high phase. The bench waits for the rise strobe and changes the code there. It then checks that the next low phase keeps the old length and the following high phase takes the new one.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_LINE = 2'd1,
        ST_HIGH_CNT  = 2'd2,
        ST_LOW_CNT   = 2'd3
    } scl_state_t;

    // Half-period multipliers, expressed as left-shift amounts
    localparam int STD_HALF_SHIFT  = 2;
    localparam int FAST_HALF_SHIFT = 1;

endpackage

// File: rtl/scl_cfg_decode.sv
`timescale 1ns/1ps
module scl_cfg_decode #(
    parameter int CODE_W          = 5,
    parameter int CNT_W           = CODE_W + 3,
    parameter int STD_MIN_CODE    = 5,
    parameter int FAST_MIN_CODE   = 3,
    parameter bit SPECIAL_EN      = 1'b1,
    parameter int SPECIAL_CODE    = 5,
    parameter int SPECIAL_LOW     = 6,
    parameter int SPECIAL_HIGH    = 4
) (
    input  logic              fast_mode,
    input  logic [CODE_W-1:0] div_code,
    output logic              legal,
    output logic [CNT_W-1:0]  low_len,
    output logic [CNT_W-1:0]  high_len
);
    import scl_gen_pkg::*;

    logic [CNT_W-1:0] code_ext;
    logic [CNT_W-1:0] std_half;
    logic [CNT_W-1:0] fast_half;
    logic             is_special;

    assign code_ext  = CNT_W'(div_code);
    assign std_half  = code_ext << STD_HALF_SHIFT;
    assign fast_half = code_ext << FAST_HALF_SHIFT;

    generate
        if (SPECIAL_EN) begin : g_special
            assign is_special = fast_mode && (int'(div_code) == SPECIAL_CODE);
        end else begin : g_no_special
            assign is_special = 1'b0;
        end
    endgenerate

    always_comb begin
        if (fast_mode) begin
            legal = (int'(div_code) >= FAST_MIN_CODE);
        end else begin
            legal = (int'(div_code) >= STD_MIN_CODE);
        end
    end

    always_comb begin
        if (is_special) begin
            low_len  = CNT_W'(SPECIAL_LOW);
            high_len = CNT_W'(SPECIAL_HIGH);
        end else if (fast_mode) begin
            low_len  = fast_half;
            high_len = fast_half;
        end else begin
            low_len  = std_half;
            high_len = std_half;
        end
    end

endmodule

// File: rtl/scl_phase_counter.sv
`timescale 1ns/1ps
module scl_phase_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/scl_rate_gen.sv
`timescale 1ns/1ps
module scl_rate_gen #(
    parameter int CODE_W        = 5,
    parameter int STD_MIN_CODE  = 5,
    parameter int FAST_MIN_CODE = 3,
    parameter int SPECIAL_CODE  = 5,
    parameter int SPECIAL_LOW   = 6,
    parameter int SPECIAL_HIGH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              fast_mode,
    input  logic [CODE_W-1:0] div_code,
    input  logic              scl_sense,
    output logic              scl_drive_low,
    output logic              scl_rise,
    output logic              scl_fall,
    output logic              cfg_error
);
    import scl_gen_pkg::*;

    localparam int CNT_W = CODE_W + 3;

    scl_state_t       state_q, state_d;
    logic             cfg_legal;
    logic [CNT_W-1:0] dec_low, dec_high;
    logic [CNT_W-1:0] lo_len_q, hi_len_q;
    logic             latch_cfg;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_last;
    logic             rise_d, fall_d;
    logic             rise_q, fall_q;

    scl_cfg_decode #(
        .CODE_W        (CODE_W),
        .CNT_W         (CNT_W),
        .STD_MIN_CODE  (STD_MIN_CODE),
        .FAST_MIN_CODE (FAST_MIN_CODE),
        .SPECIAL_EN    (1'b1),
        .SPECIAL_CODE  (SPECIAL_CODE),
        .SPECIAL_LOW   (SPECIAL_LOW),
        .SPECIAL_HIGH  (SPECIAL_HIGH)
    ) u_decode (
        .fast_mode (fast_mode),
        .div_code  (div_code),
        .legal     (cfg_legal),
        .low_len   (dec_low),
        .high_len  (dec_high)
    );

    scl_phase_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (tick),
        .last     (cnt_last)
    );

    // Next-state and control decisions
    always_comb begin
        state_d   = state_q;
        latch_cfg = 1'b0;
        cnt_load  = 1'b0;
        cnt_val   = hi_len_q - CNT_W'(1);
        rise_d    = 1'b0;
        fall_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && cfg_legal) begin
                    state_d   = ST_WAIT_LINE;
                    latch_cfg = 1'b1;
                end
            end
            ST_WAIT_LINE: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                end else if (tick && scl_sense) begin
                    // This tick is the first counted high tick
                    state_d  = ST_HIGH_CNT;
                    cnt_load = 1'b1;
                    cnt_val  = hi_len_q - CNT_W'(1);
                    rise_d   = 1'b1;
                end
            end
            ST_HIGH_CNT: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                end else if (tick && cnt_last) begin
                    state_d  = ST_LOW_CNT;
                    cnt_load = 1'b1;
                    cnt_val  = lo_len_q;
                    fall_d   = 1'b1;
                end
            end
            ST_LOW_CNT: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                end else if (tick && cnt_last) begin
                    if (cfg_legal) begin
                        state_d   = ST_WAIT_LINE;
                        latch_cfg = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and configuration latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            lo_len_q <= CNT_W'(SPECIAL_LOW);
            hi_len_q <= CNT_W'(SPECIAL_HIGH);
        end else begin
            state_q <= state_d;
            if (latch_cfg) begin
                lo_len_q <= dec_low;
                hi_len_q <= dec_high;
            end
        end
    end

    // Registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= rise_d;
            fall_q <= fall_d;
        end
    end

    assign scl_drive_low = (state_q == ST_LOW_CNT);
    assign scl_rise      = rise_q;
    assign scl_fall      = fall_q;
    assign cfg_error     = !cfg_legal;

endmodule

// File: rtl/scl_rate_gen_chk.sv
`timescale 1ns/1ps
module scl_rate_gen_chk #(
    parameter int MIN_LOW_TICKS = 6
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic enable,
    input logic scl_sense,
    input logic scl_drive_low,
    input logic scl_rise,
    input logic scl_fall
);
    logic [15:0] low_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_ticks <= '0;
        end else if (!scl_drive_low) begin
            low_ticks <= '0;
        end else if (tick) begin
            low_ticks <= low_ticks + 16'd1;
        end
    end

    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low); // R7

    AST_FALL_AT_LOW_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> scl_fall); // R9

    AST_FALL_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> scl_drive_low); // R9

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall)); // R9

    AST_RISE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (!scl_drive_low && $past(scl_sense) && $past(tick))); // R6

    AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_drive_low) && $past(enable)) |-> (low_ticks >= 16'(MIN_LOW_TICKS))); // R5

endmodule

bind scl_rate_gen scl_rate_gen_chk #(.MIN_LOW_TICKS(6)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .enable        (enable),
    .scl_sense     (scl_sense),
    .scl_drive_low (scl_drive_low),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall)
);

// File: tb/scl_rate_gen_bench.sv
`timescale 1ns/1ps
module scl_rate_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic       fast = 1'b0;
    logic       stretch = 1'b0;
    logic [4:0] code = 5'd5;
    logic       drv, rise, fall, err;
    logic       sense;
    int         nchk = 0;
    int         nfail = 0;
    int         tick_period = 1;
    int         tick_ph = 0;

    assign sense = !drv && !stretch;

    always #2 clk = ~clk;

    scl_rate_gen u_scl_rate_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .enable        (en),
        .fast_mode     (fast),
        .div_code      (code),
        .scl_sense     (sense),
        .scl_drive_low (drv),
        .scl_rise      (rise),
        .scl_fall      (fall),
        .cfg_error     (err)
    );

    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick = (tick_ph == 0);
            tick_ph = (tick_ph + 1 >= tick_period) ? 0 : tick_ph + 1;
        end
    end

    initial begin
        #760000;
        nfail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_err(input bit f, input int c);
        return f ? (c < 3) : (c < 5);
    endfunction

    function automatic int exp_lo(input bit f, input int c);
        if (f && c == 5) return 6;
        return f ? 2 * c : 4 * c;
    endfunction

    function automatic int exp_hi(input bit f, input int c);
        if (f && c == 5) return 4;
        return f ? 2 * c : 4 * c;
    endfunction

    task automatic set_in(input bit e, input bit f, input int c);
        @(posedge clk);
        #1;
        en = e;
        fast = f;
        code = 5'(c);
    endtask

    // Measures the next complete low phase and the high phase after it
    task automatic measure(output int lo, output int hi, output int lo_cyc,
                           output bit fall_ok, output int rises);
        int guard;
        guard = 0; lo = 0; hi = 0; lo_cyc = 0; rises = 0;
        @(negedge clk);
        while (drv && guard < 4000) begin @(negedge clk); guard++; end
        while (!drv && guard < 4000) begin @(negedge clk); guard++; end
        fall_ok = fall;
        while (drv && guard < 4000) begin
            if (tick) lo++;
            lo_cyc++;
            @(negedge clk); guard++;
        end
        while (!drv && guard < 4000) begin
            if (tick && sense) hi++;
            if (rise) rises++;
            @(negedge clk); guard++;
        end
    endtask

    initial begin
        int  lo, hi, lo_cyc, rises, lowcnt;
        bit  fok;

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(drv == 1'b0 && rise == 1'b0 && fall == 1'b0, "R7 reset released", int'(drv), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Sweep both modes over every code
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 32; c++) begin
                set_in(1'b0, 1'(f), c);
                @(negedge clk);
                check(err == exp_err(1'(f), c), f ? "R4 fast error flag" : "R4 std error flag",
                      int'(err), int'(exp_err(1'(f), c)));
                set_in(1'b1, 1'(f), c);
                if (exp_err(1'(f), c)) begin
                    lowcnt = 0;
                    for (int k = 0; k < 60; k++) begin
                        @(negedge clk);
                        if (drv) lowcnt++;
                    end
                    check(lowcnt == 0, "R4 illegal code keeps line released", lowcnt, 0);
                end else begin
                    @(negedge clk);
                    check(drv == 1'b0, "R7 start released", int'(drv), 0);
                    measure(lo, hi, lo_cyc, fok, rises);
                    if (f == 1 && c == 5) begin
                        check(lo == 6, "R3 special low", lo, 6);
                        check(hi == 4, "R3 special high", hi, 4);
                    end else if (f == 1) begin
                        check(lo == exp_lo(1'b1, c), "R2 fast low", lo, exp_lo(1'b1, c));
                        check(hi == exp_hi(1'b1, c), "R2 fast high", hi, exp_hi(1'b1, c));
                    end else begin
                        check(lo == exp_lo(1'b0, c), "R1 std low", lo, exp_lo(1'b0, c));
                        check(hi == exp_hi(1'b0, c), "R1 std high", hi, exp_hi(1'b0, c));
                    end
                    check(lo >= 6, "R5 low minimum", lo, 6);
                    check(fok == 1'b1, "R9 fall strobe at low start", int'(fok), 1);
                    check(rises == 1, "R9 one rise per high", rises, 1);
                end
                set_in(1'b0, 1'(f), c);
                @(posedge clk);
                @(negedge clk);
                check(drv == 1'b0, "R7 disabled released", int'(drv), 0);
            end
        end

        // R7: disable in the middle of a low phase
        set_in(1'b1, 1'b0, 5);
        while (!drv) @(negedge clk);
        @(posedge clk); #1 en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(drv == 1'b0, "R7 release one clock after enable falls", int'(drv), 0);

        // R8: code change inside a high phase
        set_in(1'b1, 1'b0, 5);
        @(negedge clk);
        while (!rise) @(negedge clk);
        @(posedge clk); #1 code = 5'd6;
        measure(lo, hi, lo_cyc, fok, rises);
        check(lo == 20, "R8 low after change keeps old length", lo, 20);
        check(hi == 24, "R8 next high uses new length", hi, 24);

        // R8: switch to an illegal code stops at the boundary
        while (!rise) @(negedge clk);
        @(posedge clk); #1 code = 5'd2;
        while (!drv) @(negedge clk);
        while (drv) @(negedge clk);
        lowcnt = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (drv) lowcnt++;
        end
        check(lowcnt == 0, "R8 illegal change halts released", lowcnt, 0);

        // R6: target holds the line low after release
        set_in(1'b0, 1'b1, 8);
        set_in(1'b1, 1'b1, 8);
        @(negedge clk);
        while (!drv) @(negedge clk);
        stretch = 1'b1;
        while (drv) @(negedge clk);
        lowcnt = 0; rises = 0;
        for (int k = 0; k < 30; k++) begin
            if (drv) lowcnt++;
            if (rise) rises++;
            @(negedge clk);
        end
        check(lowcnt == 0 && rises == 0, "R6 no drive and no rise while held", lowcnt + rises, 0);
        @(posedge clk); #1 stretch = 1'b0;
        hi = 0; rises = 0;
        @(negedge clk);
        while (!drv) begin
            if (tick && sense) hi++;
            if (rise) rises++;
            @(negedge clk);
        end
        check(hi == 16, "R6 high counted after line rises", hi, 16);
        check(rises == 1, "R6 rise after stretch", rises, 1);

        // R10: sparse base clock enable
        set_in(1'b0, 1'b1, 5);
        tick_period = 3;
        set_in(1'b1, 1'b1, 5);
        measure(lo, hi, lo_cyc, fok, rises);
        check(lo == 6, "R10 low ticks with sparse tick", lo, 6);
        check(hi == 4, "R10 high ticks with sparse tick", hi, 4);
        check(lo_cyc == 18, "R10 low phase cycles", lo_cyc, 18);
        set_in(1'b0, 1'b1, 5);
        tick_period = 1;
        repeat (4) @(posedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule